// File: doc/BRIEF.md
# Prioritised Interrupt Router with Transfer-Controller Steering

This block collects interrupt requests from a set of external lines and from the interrupt sources of several on-chip peripheral modules. It selects the most urgent eligible one for a processor that carries a 3-bit interrupt mask. Each external line has its own 3-bit priority, and each peripheral module has one 3-bit priority that all of its sources share. A rising edge on an enabled external line is captured and kept until that request is served. A peripheral source requests only while its flag input is high.

Arbitration takes place only at instruction boundaries, which the processor signals with a strobe. The winner goes to the processor or, when its steering bit is set, to a data transfer controller. The processor side receives a vector number, the new mask level and a trace-clear indication. The controller side receives the index of the source. After the processor signals a return from exception, the router lets one more instruction start before it takes any request.

Top module: `intc_router`

## Requirements
- R1: External line i uses priority field ext_prio_i[3i+2:3i]. Internal source k belongs to module k / SRC_PER_MOD and uses that module's field mod_prio_i. A higher level wins over a lower one whatever the source indices.
- R2: A source is a candidate only if its level is strictly greater than cpu_mask_i. With no candidate, nothing is issued.
- R3: Among candidates of equal level, the lowest source index wins. External line i has index i and internal source k has index N_EXT+k, so within a module the lower k wins.
- R4: A rising edge on an enabled external line sets a pending bit. The bit stays set while the line is masked, and the request is taken once the mask falls below its level.
- R5: Internal sources are not latched. A flag that drops before the instruction boundary produces no request.
- R6: An edge on a disabled external line is discarded, even if the line is enabled afterwards. An internal source whose enable bit is low never requests.
- R7: When a winner is routed to the processor, the outputs change one clock after the boundary. cpu_irq_o and cpu_clr_trace_o go high, cpu_vec_o equals VEC_BASE plus the source index, and cpu_new_mask_o equals the winner's level. These values are held until cpu_ack_i.
- R8: When dte_i[index] is 1, the winner raises dtc_req_o with dtc_src_o equal to its index and does not raise cpu_irq_o. The request is held until dtc_ack_i.
- R9: An acknowledge from the processor or from the transfer controller clears the pending bit of the served external line. A later boundary then issues nothing for that line.
- R10: After an rte_i pulse, the first boundary is skipped. The second boundary arbitrates normally.
- R11: After reset all outputs are low. No request is issued in a cycle without insn_bound_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_i | input | N_EXT | External request lines (edge-captured) |
| ext_en_i | input | N_EXT | External line enables |
| int_flag_i | input | N_MOD*SRC_PER_MOD | Peripheral interrupt flags (level) |
| int_en_i | input | N_MOD*SRC_PER_MOD | Peripheral source enables |
| ext_prio_i | input | N_EXT*3 | Per-line priority levels |
| mod_prio_i | input | N_MOD*3 | Per-module priority levels |
| dte_i | input | N_EXT+N_MOD*SRC_PER_MOD | Route-to-transfer-controller bit per source |
| cpu_mask_i | input | 3 | Current processor mask level |
| insn_bound_i | input | 1 | Instruction boundary strobe |
| rte_i | input | 1 | Return-from-exception pulse |
| cpu_ack_i | input | 1 | Processor accepts the presented request |
| dtc_ack_i | input | 1 | Transfer controller accepts its request |
| cpu_irq_o | output | 1 | Interrupt request to processor |
| cpu_vec_o | output | VW | Vector number |
| cpu_new_mask_o | output | 3 | Mask level to load on entry |
| cpu_clr_trace_o | output | 1 | Clear trace bit on entry |
| dtc_req_o | output | 1 | Request to transfer controller |
| dtc_src_o | output | $clog2(N_SRC) | Source index for the transfer |

## Verification
The bench checks the mask at its limits. A level equal to the mask must stay pending, and a design that compared with greater-or-equal would issue it. It sets up equal-level ties and a low-index source against a high-level module, so an arbiter that favoured the last index or ignored levels would report the wrong vector. It drops an internal flag before a boundary and offers edges on disabled lines, which a design that latched every input would still serve. It also counts boundaries after a return: a design without the one-instruction gap issues a request one boundary early, and a design that fails to clear served pending bits issues the same request again.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PW = 3;
  typedef logic [PW-1:0] lvl_t;
endpackage

// File: rtl/intc_ext_latch.sv
module intc_ext_latch #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      // a fresh edge wins over a clear arriving in the same cycle
      pend_q <= (pend_q & ~clr_i) | (req_i & ~req_q & en_i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_prio_map.sv
module intc_prio_map
  import intc_pkg::*;
#(
  parameter int N_EXT       = 6,
  parameter int N_MOD       = 4,
  parameter int SRC_PER_MOD = 2,
  localparam int N_INT = N_MOD * SRC_PER_MOD,
  localparam int N_SRC = N_EXT + N_INT
) (
  input  logic [N_EXT-1:0]    pend_i,
  input  logic [N_EXT-1:0]    ext_en_i,
  input  logic [N_INT-1:0]    flag_i,
  input  logic [N_INT-1:0]    int_en_i,
  input  logic [N_EXT*PW-1:0] ext_prio_i,
  input  logic [N_MOD*PW-1:0] mod_prio_i,
  output logic [N_SRC-1:0]    cand_o,
  output logic [N_SRC*PW-1:0] prio_o
);
  for (genvar e = 0; e < N_EXT; e++) begin : g_ext
    assign cand_o[e]           = pend_i[e] & ext_en_i[e];
    assign prio_o[e*PW +: PW]  = ext_prio_i[e*PW +: PW];
  end

  for (genvar k = 0; k < N_INT; k++) begin : g_int
    localparam int MOD = k / SRC_PER_MOD;
    assign cand_o[N_EXT+k]              = flag_i[k] & int_en_i[k];
    assign prio_o[(N_EXT+k)*PW +: PW]   = mod_prio_i[MOD*PW +: PW];
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N_SRC = 14,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]    cand_i,
  input  logic [N_SRC*PW-1:0] prio_i,
  input  lvl_t                mask_i,
  output logic                found_o,
  output logic [IW-1:0]       idx_o,
  output lvl_t                lvl_o
);
  always_comb begin
    lvl_t best;
    best    = mask_i;
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      // strict compare: beats the mask, and earlier index keeps ties
      if (cand_i[i] && (prio_i[i*PW +: PW] > best)) begin
        best    = prio_i[i*PW +: PW];
        idx_o   = IW'(i);
        found_o = 1'b1;
      end
    end
    lvl_o = best;
  end
endmodule

// File: rtl/intc_router.sv
module intc_router
  import intc_pkg::*;
#(
  parameter int N_EXT       = 6,
  parameter int N_MOD       = 4,
  parameter int SRC_PER_MOD = 2,
  parameter int VW          = 8,
  parameter int VEC_BASE    = 64,
  localparam int N_INT = N_MOD * SRC_PER_MOD,
  localparam int N_SRC = N_EXT + N_INT,
  localparam int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_EXT-1:0]    ext_req_i,
  input  logic [N_EXT-1:0]    ext_en_i,
  input  logic [N_INT-1:0]    int_flag_i,
  input  logic [N_INT-1:0]    int_en_i,
  input  logic [N_EXT*PW-1:0] ext_prio_i,
  input  logic [N_MOD*PW-1:0] mod_prio_i,
  input  logic [N_SRC-1:0]    dte_i,
  input  logic [PW-1:0]       cpu_mask_i,
  input  logic                insn_bound_i,
  input  logic                rte_i,
  input  logic                cpu_ack_i,
  input  logic                dtc_ack_i,
  output logic                cpu_irq_o,
  output logic [VW-1:0]       cpu_vec_o,
  output logic [PW-1:0]       cpu_new_mask_o,
  output logic                cpu_clr_trace_o,
  output logic                dtc_req_o,
  output logic [IW-1:0]       dtc_src_o
);
  logic [N_EXT-1:0]    pend;
  logic [N_EXT-1:0]    clr;
  logic [N_SRC-1:0]    cand;
  logic [N_SRC*PW-1:0] prio;
  logic                found;
  logic [IW-1:0]       win_idx;
  lvl_t                win_lvl;

  logic          cpu_irq_q, trace_q, dtc_req_q, gap_q;
  logic [IW-1:0] cpu_src_q, dtc_src_q;
  logic [VW-1:0] vec_q;
  lvl_t          nmask_q;
  logic          cpu_done, dtc_done, take;

  assign cpu_done = cpu_irq_q & cpu_ack_i;
  assign dtc_done = dtc_req_q & dtc_ack_i;

  for (genvar e = 0; e < N_EXT; e++) begin : g_clr
    assign clr[e] = (cpu_done && (cpu_src_q == IW'(e))) ||
                    (dtc_done && (dtc_src_q == IW'(e)));
  end

  intc_ext_latch #(.N(N_EXT)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .req_i  (ext_req_i),
    .en_i   (ext_en_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  intc_prio_map #(
    .N_EXT(N_EXT), .N_MOD(N_MOD), .SRC_PER_MOD(SRC_PER_MOD)
  ) u_map (
    .pend_i     (pend),
    .ext_en_i   (ext_en_i),
    .flag_i     (int_flag_i),
    .int_en_i   (int_en_i),
    .ext_prio_i (ext_prio_i),
    .mod_prio_i (mod_prio_i),
    .cand_o     (cand),
    .prio_o     (prio)
  );

  intc_arbiter #(.N_SRC(N_SRC)) u_arb (
    .cand_i  (cand),
    .prio_i  (prio),
    .mask_i  (cpu_mask_i),
    .found_o (found),
    .idx_o   (win_idx),
    .lvl_o   (win_lvl)
  );

  // evaluate only at a boundary that is not the one right after a return
  assign take = insn_bound_i & ~gap_q & ~rte_i & ~cpu_irq_q & ~dtc_req_q & found;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq_q <= 1'b0;
      trace_q   <= 1'b0;
      dtc_req_q <= 1'b0;
      gap_q     <= 1'b0;
      cpu_src_q <= '0;
      dtc_src_q <= '0;
      vec_q     <= '0;
      nmask_q   <= '0;
    end else begin
      if (cpu_done) begin
        cpu_irq_q <= 1'b0;
        trace_q   <= 1'b0;
      end
      if (dtc_done) dtc_req_q <= 1'b0;

      if (rte_i)                      gap_q <= 1'b1;
      else if (insn_bound_i && gap_q) gap_q <= 1'b0;

      if (take) begin
        if (dte_i[win_idx]) begin
          dtc_req_q <= 1'b1;
          dtc_src_q <= win_idx;
        end else begin
          cpu_irq_q <= 1'b1;
          trace_q   <= 1'b1;
          cpu_src_q <= win_idx;
          vec_q     <= VW'(VEC_BASE) + VW'(win_idx);
          nmask_q   <= win_lvl;
        end
      end
    end
  end

  assign cpu_irq_o       = cpu_irq_q;
  assign cpu_clr_trace_o = trace_q;
  assign cpu_vec_o       = vec_q;
  assign cpu_new_mask_o  = nmask_q;
  assign dtc_req_o       = dtc_req_q;
  assign dtc_src_o       = dtc_src_q;
endmodule

// File: rtl/intc_router_chk.sv
module intc_router_chk #(
  parameter int N_SRC    = 14,
  parameter int IW       = 4,
  parameter int VW       = 8,
  parameter int VEC_BASE = 64
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cpu_mask_i,
  input logic          insn_bound_i,
  input logic          rte_i,
  input logic          cpu_ack_i,
  input logic          dtc_ack_i,
  input logic          cpu_irq_o,
  input logic [VW-1:0] cpu_vec_o,
  input logic [2:0]    cpu_new_mask_o,
  input logic          cpu_clr_trace_o,
  input logic          dtc_req_o,
  input logic [IW-1:0] dtc_src_o
);
  // R2: a newly issued level beats the mask sampled at the boundary
  p_above_mask_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_irq_o) |-> (cpu_new_mask_o > $past(cpu_mask_i)));

  // R7: processor request and its fields hold until acknowledged
  p_cpu_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq_o && !cpu_ack_i) |=> (cpu_irq_o && $stable(cpu_vec_o) && $stable(cpu_new_mask_o)));

  // R7: vector lies in the source range and trace clear accompanies it
  p_vec_range_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_irq_o |-> (cpu_clr_trace_o && cpu_vec_o >= VW'(VEC_BASE) && cpu_vec_o < VW'(VEC_BASE + N_SRC)));

  // R8: transfer request holds its source until acknowledged
  p_dtc_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (dtc_req_o && !dtc_ack_i) |=> (dtc_req_o && $stable(dtc_src_o)));

  // R8: a source goes to one destination only
  p_one_dest_r8: assert property (@(posedge clk) disable iff (rst)
    !(cpu_irq_o && dtc_req_o));

  // R10: the cycle of a return never issues
  p_no_issue_on_rte_r10: assert property (@(posedge clk) disable iff (rst)
    (rte_i && !cpu_irq_o) |=> !cpu_irq_o);

  // R11: issue only follows a boundary strobe
  p_boundary_only_r11: assert property (@(posedge clk) disable iff (rst)
    ($rose(cpu_irq_o) || $rose(dtc_req_o)) |-> $past(insn_bound_i));
endmodule

bind intc_router intc_router_chk #(
  .N_SRC(N_SRC), .IW(IW), .VW(VW), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cpu_mask_i      (cpu_mask_i),
  .insn_bound_i    (insn_bound_i),
  .rte_i           (rte_i),
  .cpu_ack_i       (cpu_ack_i),
  .dtc_ack_i       (dtc_ack_i),
  .cpu_irq_o       (cpu_irq_o),
  .cpu_vec_o       (cpu_vec_o),
  .cpu_new_mask_o  (cpu_new_mask_o),
  .cpu_clr_trace_o (cpu_clr_trace_o),
  .dtc_req_o       (dtc_req_o),
  .dtc_src_o       (dtc_src_o)
);

// File: tb/tb_intc_router.sv
module tb_intc_router;
  localparam int N_EXT = 6, N_MOD = 4, SPM = 2, VW = 8, VB = 64;
  localparam int N_INT = N_MOD * SPM;
  localparam int N_SRC = N_EXT + N_INT;
  localparam int IW = $clog2(N_SRC);

  logic clk = 0, rst = 1;
  logic [N_EXT-1:0]   ext_req = '0, ext_en = '0;
  logic [N_INT-1:0]   int_flag = '0, int_en = '0;
  logic [N_EXT*3-1:0] ext_prio = '0;
  logic [N_MOD*3-1:0] mod_prio = '0;
  logic [N_SRC-1:0]   dte = '0;
  logic [2:0]         mask = '0;
  logic bound = 0, rte = 0, cack = 0, dack = 0;
  logic cirq, ctrace, dreq;
  logic [VW-1:0] cvec;
  logic [2:0]    cmask;
  logic [IW-1:0] dsrc;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  intc_router #(.N_EXT(N_EXT), .N_MOD(N_MOD), .SRC_PER_MOD(SPM), .VW(VW), .VEC_BASE(VB)) dut (
    .clk(clk), .rst(rst), .ext_req_i(ext_req), .ext_en_i(ext_en),
    .int_flag_i(int_flag), .int_en_i(int_en), .ext_prio_i(ext_prio),
    .mod_prio_i(mod_prio), .dte_i(dte), .cpu_mask_i(mask),
    .insn_bound_i(bound), .rte_i(rte), .cpu_ack_i(cack), .dtc_ack_i(dack),
    .cpu_irq_o(cirq), .cpu_vec_o(cvec), .cpu_new_mask_o(cmask),
    .cpu_clr_trace_o(ctrace), .dtc_req_o(dreq), .dtc_src_o(dsrc));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_bound();
    bound = 1; @(negedge clk); bound = 0;
  endtask

  task automatic edge_ext(input int e);
    ext_req[e] = 1; @(negedge clk); ext_req[e] = 0; @(negedge clk);
  endtask

  task automatic ack_cpu();
    cack = 1; @(negedge clk); cack = 0;
  endtask

  task automatic expect_cpu(input string req, input int vec, input int lvl);
    chk(cirq == 1, {req, " irq"}, cirq, 1);
    chk(int'(cvec) == vec, {req, " vector"}, cvec, vec);
    chk(int'(cmask) == lvl, {req, " new mask"}, cmask, lvl);
    chk(ctrace == 1, {req, " trace clear"}, ctrace, 1);
  endtask

  task automatic t_reset();
    chk(cirq == 0 && dreq == 0 && ctrace == 0, "R11 reset outputs", {cirq, dreq, ctrace}, 0);
  endtask

  task automatic t_basic();
    ext_en = '1; mask = 3; ext_prio[2*3 +: 3] = 5;
    edge_ext(2);
    cyc(3);
    chk(cirq == 0, "R11 no boundary no issue", cirq, 0);
    do_bound();
    expect_cpu("R7 line2", VB + 2, 5);
    ack_cpu();
    chk(cirq == 0, "R9 irq dropped on ack", cirq, 1'b0);
    do_bound();
    chk(cirq == 0, "R9 served line not reissued", cirq, 0);
  endtask

  task automatic t_mask();
    mask = 4; ext_prio[1*3 +: 3] = 4;
    edge_ext(1);
    do_bound();
    chk(cirq == 0, "R2 level equal to mask held", cirq, 0);
    mask = 3;
    do_bound();
    expect_cpu("R4 pending taken after unmask", VB + 1, 4);
    ack_cpu();
  endtask

  task automatic t_ties();
    mask = 0; ext_prio[0 +: 3] = 6; ext_prio[1*3 +: 3] = 6;
    ext_req[0] = 1; ext_req[1] = 1; @(negedge clk); ext_req = '0; @(negedge clk);
    do_bound();
    expect_cpu("R3 external tie", VB + 0, 6);
    ack_cpu();
    do_bound();
    expect_cpu("R3 second of tie", VB + 1, 6);
    ack_cpu();
    int_en = '1; mod_prio[1*3 +: 3] = 5; int_flag[2] = 1; int_flag[3] = 1;
    @(negedge clk);
    do_bound();
    expect_cpu("R3 in-module order", VB + N_EXT + 2, 5);
    ack_cpu();
    int_flag = '0;
  endtask

  task automatic t_levels();
    mask = 0; ext_prio[0 +: 3] = 2; mod_prio[2*3 +: 3] = 7;
    edge_ext(0);
    int_flag[5] = 1;
    @(negedge clk);
    do_bound();
    expect_cpu("R1 module level beats low index", VB + N_EXT + 5, 7);
    ack_cpu();
    int_flag = '0;
    do_bound();
    expect_cpu("R1 line0 own level", VB + 0, 2);
    ack_cpu();
  endtask

  task automatic t_unlatched();
    mod_prio[0 +: 3] = 6; int_flag[1] = 1; @(negedge clk); int_flag[1] = 0; @(negedge clk);
    do_bound();
    chk(cirq == 0, "R5 dropped flag not latched", cirq, 0);
  endtask

  task automatic t_disabled();
    ext_en[4] = 0; ext_prio[4*3 +: 3] = 7;
    edge_ext(4);
    ext_en[4] = 1;
    do_bound();
    chk(cirq == 0, "R6 edge on disabled line", cirq, 0);
    int_en[0] = 0; int_flag[0] = 1; @(negedge clk);
    do_bound();
    chk(cirq == 0, "R6 disabled internal source", cirq, 0);
    int_flag = '0; int_en = '1;
  endtask

  task automatic t_dtc();
    dte[3] = 1; ext_prio[3*3 +: 3] = 5;
    edge_ext(3);
    do_bound();
    chk(dreq == 1 && int'(dsrc) == 3, "R8 routed to transfer ctrl", dsrc, 3);
    chk(cirq == 0, "R8 no cpu request", cirq, 0);
    dack = 1; @(negedge clk); dack = 0;
    chk(dreq == 0, "R8 dtc req dropped on ack", dreq, 0);
    do_bound();
    chk(dreq == 0 && cirq == 0, "R9 dtc ack clears pending", {dreq, cirq}, 0);
    dte = '0;
  endtask

  task automatic t_gap();
    mask = 7; ext_prio[2*3 +: 3] = 5;
    edge_ext(2);
    rte = 1; mask = 0; @(negedge clk); rte = 0;
    do_bound();
    chk(cirq == 0, "R10 first boundary after return skipped", cirq, 0);
    do_bound();
    expect_cpu("R10 second boundary issues", VB + 2, 5);
    ack_cpu();
  endtask

  initial begin
    fork
      begin
        cyc(3); rst = 0; @(negedge clk);
        t_reset();
        t_basic();
        t_mask();
        t_ties();
        t_levels();
        t_unlatched();
        t_disabled();
        t_dtc();
        t_gap();
      end
      begin
        cyc(20000);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule